// File: doc/BRIEF.md
# Byte ALU with Per-Flag Write Enables

This is a purely combinational 8-bit arithmetic and logic unit for a small microcontroller core that uses a 14-bit instruction word. It decodes the instruction and uses four other inputs: the working register W, the file-register operand, the incoming carry and, for literal forms, the low byte of the instruction. From these it produces an 8-bit result and a signal that says whether the result goes to the file register or to W. It also produces the carry, digit-carry and zero flag values, each with its own write enable.

The surrounding core places the unit between operand fetch and write-back. The core commits the result only when `res_valid` is high. It updates each flag only when that flag's enable is high.

Register addressing, banking, control flow and any other instruction groups belong to the core. Any opcode this unit does not handle leaves every enable low.

Top module: `byte_alu`

## Requirements
- R1: The add operations (opcode bits 13..8: 000111 W+f, 111101 W+f+c_in, 111110 W+literal) return the 8-bit sum. They write C with the carry out of bit 7, DC with the carry out of bit 3, and Z.
- R2: The subtract operations (111011 f−W, 000010 f−W−(1−c_in), 111100 literal−W) return the 8-bit difference. They write C=1 when no borrow occurs, DC=1 when the low nibble produces no borrow, and Z.
- R3: The following operations write only Z. AND, OR and XOR with f (000101, 000100, 000110) and with the literal (111001, 111000, 111010). Complement f (001001), decrement f (000011), increment f (001010) and pass f (001000).
- R4: The shifts write C and Z. Arithmetic right shift (110111) keeps bit 7. Logical right shift (110110) fills bit 7 with 0. Left shift (110101) fills bit 0 with 0. C receives the bit shifted out.
- R5: The rotates through carry write only C. Left rotate (001101) is {f[6:0],c_in} with C=f[7]. Right rotate (001100) is {c_in,f[7:1]} with C=f[0].
- R6: Nibble swap (001110) returns {f[3:0],f[7:4]} and load literal (110000) returns the literal. Neither writes any flag.
- R7: The clear operations write 0 and set Z. Opcode 000001 with bit 7 set clears f. Opcode 000001 with bits 7..2 all zero clears W.
- R8: Opcode 000000 with bit 7 set returns W toward f and writes no flag.
- R9: For the byte operations, `dest_f` equals instruction bit 7. It is 0 for the literal operations and for the W clear, and 1 for the f clear and the W-to-f move.
- R10: Whenever Z is written, `z_out` is 1 exactly when the 8-bit result is zero.
- R11: Any other instruction word drives `res_valid`, `c_we`, `dc_we` and `z_we` low. This includes opcode 000001 with bit 7 clear and bits 6..2 nonzero, and opcode 000000 with bit 7 clear.
- R12: `res_valid` is high for every operation listed in R1 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 14 | Instruction word |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | File-register operand |
| c_in | input | 1 | Current carry flag |
| result | output | 8 | Operation result |
| res_valid | output | 1 | Instruction is an operation of this unit |
| dest_f | output | 1 | 1: result to file register, 0: result to W |
| c_we | output | 1 | Write enable for C |
| c_out | output | 1 | New C value |
| dc_we | output | 1 | Write enable for DC |
| dc_out | output | 1 | New DC value |
| z_we | output | 1 | Write enable for Z |
| z_out | output | 1 | New Z value |

## Verification
The unit has no parameters, so the bench builds it at its fixed 8-bit width and 14-bit instruction. This makes the whole opcode space reachable in one build. Random operands on every listed opcode, mixed with fully random instruction words, cover carry chains, borrow through the low nibble and the unused encodings. Directed vectors cover the cases below, and DC and C are compared only where the model expects a write:
- wrap-around to zero
- equal-operand subtraction
- borrow with the incoming carry cleared
- sign fill on the arithmetic shift
- the boundary between the W clear and an unhandled 000001 word

// File: rtl/byte_alu.sv
module byte_alu (
  input  logic [13:0] instr,
  input  logic [7:0]  w_in,
  input  logic [7:0]  f_in,
  input  logic        c_in,
  output logic [7:0]  result,
  output logic        res_valid,
  output logic        dest_f,
  output logic        c_we,
  output logic        c_out,
  output logic        dc_we,
  output logic        dc_out,
  output logic        z_we,
  output logic        z_out
);

  logic [5:0] op;
  logic       dbit;
  logic [7:0] lit;
  logic [7:0] aa, bb;
  logic       ci, arith;
  logic [4:0] lo_sum, hi_sum;

  assign op   = instr[13:8];
  assign dbit = instr[7];
  assign lit  = instr[7:0];

  always_comb begin
    res_valid = 1'b0;
    dest_f    = 1'b0;
    result    = 8'h00;
    c_we      = 1'b0;
    c_out     = 1'b0;
    dc_we     = 1'b0;
    dc_out    = 1'b0;
    z_we      = 1'b0;
    aa        = f_in;
    bb        = w_in;
    ci        = 1'b0;
    arith     = 1'b0;

    case (op)
      6'b000111: begin arith = 1'b1; dest_f = dbit; end
      6'b111101: begin arith = 1'b1; dest_f = dbit; ci = c_in; end
      6'b111110: begin arith = 1'b1; aa = lit; end
      6'b111011: begin arith = 1'b1; dest_f = dbit; bb = ~w_in; ci = 1'b1; end
      6'b000010: begin arith = 1'b1; dest_f = dbit; bb = ~w_in; ci = c_in; end
      6'b111100: begin arith = 1'b1; aa = lit; bb = ~w_in; ci = 1'b1; end
      6'b000101: begin res_valid = 1'b1; z_we = 1'b1; dest_f = dbit; result = w_in & f_in; end
      6'b000100: begin res_valid = 1'b1; z_we = 1'b1; dest_f = dbit; result = w_in | f_in; end
      6'b000110: begin res_valid = 1'b1; z_we = 1'b1; dest_f = dbit; result = w_in ^ f_in; end
      6'b001001: begin res_valid = 1'b1; z_we = 1'b1; dest_f = dbit; result = ~f_in; end
      6'b000011: begin res_valid = 1'b1; z_we = 1'b1; dest_f = dbit; result = f_in - 8'd1; end
      6'b001010: begin res_valid = 1'b1; z_we = 1'b1; dest_f = dbit; result = f_in + 8'd1; end
      6'b001000: begin res_valid = 1'b1; z_we = 1'b1; dest_f = dbit; result = f_in; end
      6'b111001: begin res_valid = 1'b1; z_we = 1'b1; result = w_in & lit; end
      6'b111000: begin res_valid = 1'b1; z_we = 1'b1; result = w_in | lit; end
      6'b111010: begin res_valid = 1'b1; z_we = 1'b1; result = w_in ^ lit; end
      6'b110111: begin
        res_valid = 1'b1; z_we = 1'b1; c_we = 1'b1; dest_f = dbit;
        result = {f_in[7], f_in[7:1]}; c_out = f_in[0];
      end
      6'b110110: begin
        res_valid = 1'b1; z_we = 1'b1; c_we = 1'b1; dest_f = dbit;
        result = {1'b0, f_in[7:1]}; c_out = f_in[0];
      end
      6'b110101: begin
        res_valid = 1'b1; z_we = 1'b1; c_we = 1'b1; dest_f = dbit;
        result = {f_in[6:0], 1'b0}; c_out = f_in[7];
      end
      6'b001101: begin
        res_valid = 1'b1; c_we = 1'b1; dest_f = dbit;
        result = {f_in[6:0], c_in}; c_out = f_in[7];
      end
      6'b001100: begin
        res_valid = 1'b1; c_we = 1'b1; dest_f = dbit;
        result = {c_in, f_in[7:1]}; c_out = f_in[0];
      end
      6'b001110: begin res_valid = 1'b1; dest_f = dbit; result = {f_in[3:0], f_in[7:4]}; end
      6'b110000: begin res_valid = 1'b1; result = lit; end
      6'b000001: begin
        if (dbit) begin
          res_valid = 1'b1; z_we = 1'b1; dest_f = 1'b1;
        end else if (instr[6:2] == 5'd0) begin
          res_valid = 1'b1; z_we = 1'b1;
        end
      end
      6'b000000: begin
        if (dbit) begin
          res_valid = 1'b1; dest_f = 1'b1; result = w_in;
        end
      end
      default: ;
    endcase

    lo_sum = {1'b0, aa[3:0]} + {1'b0, bb[3:0]} + {4'd0, ci};
    hi_sum = {1'b0, aa[7:4]} + {1'b0, bb[7:4]} + {4'd0, lo_sum[4]};
    if (arith) begin
      res_valid = 1'b1;
      result    = {hi_sum[3:0], lo_sum[3:0]};
      c_we      = 1'b1;
      dc_we     = 1'b1;
      z_we      = 1'b1;
      c_out     = hi_sum[4];
      dc_out    = lo_sum[4];
    end
  end

  assign z_out = (result == 8'h00);

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk (
  input logic [13:0] instr,
  input logic [7:0]  w_in,
  input logic [7:0]  f_in,
  input logic        c_in,
  input logic [7:0]  result,
  input logic        res_valid,
  input logic        dest_f,
  input logic        c_we,
  input logic        c_out,
  input logic        dc_we,
  input logic        dc_out,
  input logic        z_we,
  input logic        z_out
);

  always_comb begin
    if (!res_valid)
      assert_idle_quiet_R11: assert (!c_we && !dc_we && !z_we);
    if (z_we)
      assert_zero_flag_R10: assert (z_out == (result == 8'h00));
    if (dc_we)
      assert_dc_pairs_c_R1: assert (c_we && z_we);
    if (instr[13:8] == 6'b001110)
      assert_swap_R6: assert (res_valid && result == {f_in[3:0], f_in[7:4]} && !c_we && !dc_we && !z_we);
    if (instr[13:7] == 7'b0000001)
      assert_move_w_R8: assert (res_valid && dest_f && result == w_in && !z_we && !c_we);
    if (instr[13:9] == 5'b00110)
      assert_rotate_R5: assert (res_valid && c_we && !z_we && !dc_we);
    if (instr[13:7] == 7'b0000011)
      assert_clear_f_R7: assert (res_valid && dest_f && result == 8'h00 && z_we && z_out);
  end

endmodule

bind byte_alu byte_alu_chk u_chk (.*);

// File: tb/byte_alu_bench.sv
module byte_alu_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [13:0] instr;
  logic [7:0]  w_in, f_in;
  logic        c_in;
  logic [7:0]  result;
  logic        res_valid, dest_f, c_we, c_out, dc_we, dc_out, z_we, z_out;

  int n_checks = 0;
  int n_fails  = 0;

  byte_alu u_byte_alu (.*);

  typedef struct packed {
    logic v; logic d; logic [7:0] r;
    logic cw; logic c; logic dw; logic dc; logic zw; logic z;
  } exp_t;

  function automatic exp_t model(input logic [13:0] ins, input logic [7:0] w, input logic [7:0] f, input logic ci);
    exp_t e;
    int s, sl, bor;
    logic [7:0] k;
    logic add, sub;
    e = '0;
    k = ins[7:0];
    add = 0; sub = 0; bor = 0;
    e.v = 1;
    e.d = ins[7];
    case (ins[13:8])
      6'b000111: begin add = 1; s = w + f; sl = (w & 15) + (f & 15); end
      6'b111101: begin add = 1; s = w + f + ci; sl = (w & 15) + (f & 15) + ci; end
      6'b111110: begin add = 1; e.d = 0; s = w + k; sl = (w & 15) + (k & 15); end
      6'b111011: begin sub = 1; s = f - w; sl = (f & 15) - (w & 15); end
      6'b000010: begin sub = 1; bor = ci ? 0 : 1; s = f - w - bor; sl = (f & 15) - (w & 15) - bor; end
      6'b111100: begin sub = 1; e.d = 0; s = k - w; sl = (k & 15) - (w & 15); end
      6'b000101: begin e.zw = 1; e.r = w & f; end
      6'b000100: begin e.zw = 1; e.r = w | f; end
      6'b000110: begin e.zw = 1; e.r = w ^ f; end
      6'b001001: begin e.zw = 1; e.r = ~f; end
      6'b000011: begin e.zw = 1; e.r = 8'((f + 255) % 256); end
      6'b001010: begin e.zw = 1; e.r = 8'((f + 1) % 256); end
      6'b001000: begin e.zw = 1; e.r = f; end
      6'b111001: begin e.zw = 1; e.d = 0; e.r = w & k; end
      6'b111000: begin e.zw = 1; e.d = 0; e.r = w | k; end
      6'b111010: begin e.zw = 1; e.d = 0; e.r = w ^ k; end
      6'b110111: begin e.zw = 1; e.cw = 1; e.c = f[0]; e.r = 8'((f / 2) + (f[7] ? 128 : 0)); end
      6'b110110: begin e.zw = 1; e.cw = 1; e.c = f[0]; e.r = 8'(f / 2); end
      6'b110101: begin e.zw = 1; e.cw = 1; e.c = f[7]; e.r = 8'((f * 2) % 256); end
      6'b001101: begin e.cw = 1; e.c = f[7]; e.r = 8'((f * 2) % 256 + ci); end
      6'b001100: begin e.cw = 1; e.c = f[0]; e.r = 8'((f / 2) + (ci ? 128 : 0)); end
      6'b001110: e.r = 8'((f % 16) * 16 + f / 16);
      6'b110000: begin e.d = 0; e.r = k; end
      6'b000001: begin
        if (ins[7]) begin e.zw = 1; e.r = 0; end
        else if (ins[6:2] == 0) begin e.zw = 1; e.r = 0; end
        else e = '0;
      end
      6'b000000: begin
        if (ins[7]) e.r = w;
        else e = '0;
      end
      default: e = '0;
    endcase
    if (add) begin
      e.r = 8'(s % 256); e.cw = 1; e.dw = 1; e.zw = 1;
      e.c = (s > 255); e.dc = (sl > 15);
    end
    if (sub) begin
      e.r = 8'((s + 512) % 256); e.cw = 1; e.dw = 1; e.zw = 1;
      e.c = (s >= 0); e.dc = (sl >= 0);
    end
    e.z = (e.r == 0);
    return e;
  endfunction

  function automatic string tag(input logic [13:0] ins);
    case (ins[13:8])
      6'b000111, 6'b111101, 6'b111110: return "R1";
      6'b111011, 6'b000010, 6'b111100: return "R2";
      6'b000101, 6'b000100, 6'b000110, 6'b001001, 6'b000011,
      6'b001010, 6'b001000, 6'b111001, 6'b111000, 6'b111010: return "R3";
      6'b110111, 6'b110110, 6'b110101: return "R4";
      6'b001101, 6'b001100: return "R5";
      6'b001110, 6'b110000: return "R6";
      6'b000001: return (ins[7] || ins[6:2] == 0) ? "R7" : "R11";
      6'b000000: return ins[7] ? "R8" : "R11";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [13:0] ins, input logic [7:0] w, input logic [7:0] f, input logic ci);
    exp_t e, a;
    logic bad;
    @(negedge clk);
    instr = ins; w_in = w; f_in = f; c_in = ci;
    #2;
    e = model(ins, w, f, ci);
    a = '{res_valid, dest_f, result, c_we, c_out, dc_we, dc_out, z_we, z_out};
    n_checks++;
    bad = (a.v != e.v) || (a.cw != e.cw) || (a.dw != e.dw) || (a.zw != e.zw);
    if (e.v) begin
      // R9 destination, R10 zero flag, R12 valid
      bad = bad || (a.d != e.d) || (a.r != e.r);
      if (e.cw && a.c != e.c) bad = 1;
      if (e.dw && a.dc != e.dc) bad = 1;
      if (e.zw && a.z != e.z) bad = 1;
    end
    if (bad) begin
      n_fails++;
      $display("FAIL %s/R9/R10/R12 instr=%h w=%h f=%h c=%b actual=%h expected=%h",
               tag(ins), ins, w, f, ci, a, e);
    end
  endtask

  localparam logic [5:0] OPS [26] = '{
    6'b000111, 6'b111101, 6'b111110, 6'b111011, 6'b000010, 6'b111100,
    6'b000101, 6'b000100, 6'b000110, 6'b001001, 6'b000011, 6'b001010,
    6'b001000, 6'b111001, 6'b111000, 6'b111010, 6'b110111, 6'b110110,
    6'b110101, 6'b001101, 6'b001100, 6'b001110, 6'b110000, 6'b000001,
    6'b000001, 6'b000000};

  initial begin
    int unused;
    unused = $urandom(32'd20240611);
    instr = '0; w_in = '0; f_in = '0; c_in = 1'b0;
    // R11: all-zero word at start leaves every enable low
    apply(14'h0000, 8'h00, 8'h00, 1'b0);
    // R1: wrap to zero with carries out of both nibble and byte
    apply({6'b000111, 8'h85}, 8'hFF, 8'h01, 1'b0);
    apply({6'b111101, 8'h05}, 8'h0F, 8'hF0, 1'b1);
    // R2: equal operands, borrow, borrow from incoming carry
    apply({6'b111011, 8'h80}, 8'h3C, 8'h3C, 1'b0);
    apply({6'b111011, 8'h00}, 8'h01, 8'h00, 1'b1);
    apply({6'b000010, 8'h80}, 8'h00, 8'h10, 1'b0);
    apply({6'b111100, 8'h05}, 8'h06, 8'h00, 1'b0);
    // R4: sign fill on arithmetic shift
    apply({6'b110111, 8'h80}, 8'h00, 8'h81, 1'b0);
    apply({6'b110101, 8'h00}, 8'h00, 8'h80, 1'b0);
    // R5: rotate brings carry in
    apply({6'b001100, 8'h80}, 8'h00, 8'h02, 1'b1);
    // R7: clears; R11: 000001 with bits 6..2 nonzero
    apply({6'b000001, 8'h83}, 8'h55, 8'hAA, 1'b1);
    apply({6'b000001, 8'h03}, 8'h55, 8'hAA, 1'b1);
    apply({6'b000001, 8'h04}, 8'h55, 8'hAA, 1'b1);
    // R8: move W to f
    apply({6'b000000, 8'h80}, 8'hC3, 8'h00, 1'b0);
    // R6: swap and literal load
    apply({6'b001110, 8'h00}, 8'h00, 8'hA5, 1'b1);
    apply({6'b110000, 8'h00}, 8'h77, 8'h11, 1'b1);
    for (int i = 0; i < 4000; i++) begin
      logic [13:0] ins;
      if ($urandom_range(9) == 0) ins = 14'($urandom);
      else ins = {OPS[$urandom_range(25)], 8'($urandom)};
      apply(ins, 8'($urandom), 8'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule